// File: doc/BRIEF.md
# TDM Transmit Channel Gating Controller

This block is the transmit half of a time-division-multiplexed serial port. A frame is a run of equal-length words, called slots, and each slot carries one channel. At the start of every slot the block decides two things for that channel. The first is whether the channel is enabled, which means the waiting holding word is copied into the shift register. The second is whether the channel is unmasked, which means the shift register is actually driven onto the serial line. One of four selection modes makes these decisions, using a transmit enable bitmap, a receive enable bitmap and a range select of 32 or 128 channels.

Software or a DMA engine refills the holding word whenever the ready flag is high. Each copy into the shift register raises the ready flag and pulses a DMA request. It also pulses an interrupt if the interrupt mode asks for one. When a slot is masked, the output-enable is low for that whole slot, which models a line in high impedance. An enabled slot that finds no fresh holding word raises an underrun pulse and sends the previously loaded word again.

The control path is a two-state machine. `ST_IDLE` waits between frames. `ST_SHIFT` shifts bits through the slots of one frame. The transition FRAME_SYNC (from any state to `ST_SHIFT`) is taken whenever the frame sync input is high. The transition NEXT_SLOT (from `ST_SHIFT` back to `ST_SHIFT`) is taken at the end of every word except the last. The transition FRAME_DONE (from `ST_SHIFT` to `ST_IDLE`) is taken at the end of the final word of the frame.

Top module: `tdm_tx_gate`

## Requirements
- R1: After reset the state is as follows: `ser_oe` and `ser_data` are 0, `tx_ready` is 1, `tx_empty` is 1, and `dma_req`, `irq` and `underrun` are 0.
- R2: In mode 2'b00, every channel is enabled and unmasked, whatever the bitmaps and the range select hold.
- R3: In mode 2'b01, a channel is enabled and unmasked only when its `tx_en_map` bit is set. Otherwise it is disabled and masked.
- R4: In mode 2'b10, every channel is enabled. A channel is unmasked only when its `tx_en_map` bit is set.
- R5: In mode 2'b11, a channel is enabled only when its `rx_en_map` bit is set. It is unmasked only when both its `rx_en_map` bit and its `tx_en_map` bit are set.
- R6: When `wide_range` is 0, channels 32 and above count as not selected in both bitmaps. When `wide_range` is 1, all 128 channels can be selected.
- R7: During an unmasked slot, `ser_oe` is 1 and the loaded word goes out MSB first over `word_len_m1`+1 cycles. The first bit is visible in the cycle after the frame-sync edge. During a masked slot, `ser_oe` and `ser_data` are 0 for the whole slot. A disabled channel is always masked.
- R8: At the start of an enabled slot that has a fresh holding word, the word is copied into the shift register. `tx_ready` goes to 1, and `dma_req` pulses for exactly the first bit cycle of the slot. A disabled slot makes no copy and no request, and its holding word stays for the next enabled slot.
- R9: `irq` pulses together with `dma_req` when `irq_on_ready` is 1. It never pulses when `irq_on_ready` is 0.
- R10: An enabled slot that has no fresh holding word pulses `underrun`, sets `tx_empty` and sends the last loaded word again. A copy clears `tx_empty`. A disabled slot leaves `tx_empty` unchanged.
- R11: Frame sync resets the channel count to 0, and the count advances once per word. After `frame_len_m1`+1 words, `ser_oe` stays 0 until the next frame sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock. Each rising edge is one bit period. |
| rst_n | input | 1 | Asynchronous reset, active low |
| fsync | input | 1 | Frame sync. One cycle high starts a frame. |
| word_len_m1 | input | 5 | Bits per word minus one, from 7 to 31 |
| frame_len_m1 | input | 7 | Words per frame minus one |
| mode | input | 2 | Selection mode, 00/01/10/11 |
| wide_range | input | 1 | 0 = 32 selectable channels, 1 = 128 |
| tx_en_map | input | 128 | Transmit channel enable bitmap |
| rx_en_map | input | 128 | Receive channel enable bitmap |
| irq_on_ready | input | 1 | Interrupt mode: pulse `irq` on each copy |
| hold_wr | input | 1 | Write strobe for the holding word |
| hold_word | input | 32 | Holding word data, right-aligned |
| ser_data | output | 1 | Serial data |
| ser_oe | output | 1 | Output enable. 0 models high impedance. |
| tx_ready | output | 1 | Holding word can take new data |
| dma_req | output | 1 | One-cycle request raised on each copy |
| irq | output | 1 | One-cycle interrupt raised on each copy |
| underrun | output | 1 | One-cycle pulse on an enabled slot with no fresh word |
| tx_empty | output | 1 | The last enabled slot had no fresh word |

## Verification
Every slot decision is registered on the edge that starts the slot. The bench therefore drives frame sync and holding-word writes on falling edges and samples on the falling edge that follows the slot-start edge. At that point the pulses `dma_req`, `irq` and `underrun` must be present. One cycle later they must be gone. Serial bit k of a slot is compared on the k-th falling edge after the slot start, together with `ser_oe`. Writes to the holding word are placed on bit 2 of a slot, well away from the boundary. This gives the bench's holding-word model an unambiguous order against each copy.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
    typedef enum logic [1:0] {
        SEL_ALL     = 2'b00,
        SEL_TX_ONLY = 2'b01,
        SEL_MASK_TX = 2'b10,
        SEL_SYMM    = 2'b11
    } sel_mode_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } tx_state_e;

    localparam int NARROW_CHANS = 32;
endpackage

// File: rtl/tdm_chan_select.sv
module tdm_chan_select
    import tdm_tx_pkg::*;
#(
    parameter int NCH = 128,
    localparam int CW = $clog2(NCH)
) (
    input  logic [1:0]     mode,
    input  logic           wide_range,
    input  logic [CW-1:0]  chan,
    input  logic [NCH-1:0] tx_map,
    input  logic [NCH-1:0] rx_map,
    output logic           chan_en,
    output logic           chan_unmask
);
    logic in_range;
    logic tx_sel;
    logic rx_sel;

    always_comb begin
        in_range = wide_range ? 1'b1 : (chan < CW'(NARROW_CHANS));
        tx_sel   = in_range & tx_map[chan];
        rx_sel   = in_range & rx_map[chan];
        unique case (sel_mode_e'(mode))
            SEL_ALL:     begin chan_en = 1'b1;   chan_unmask = 1'b1;            end
            SEL_TX_ONLY: begin chan_en = tx_sel; chan_unmask = tx_sel;          end
            SEL_MASK_TX: begin chan_en = 1'b1;   chan_unmask = tx_sel;          end
            SEL_SYMM:    begin chan_en = rx_sel; chan_unmask = rx_sel & tx_sel; end
            default:     begin chan_en = 1'b0;   chan_unmask = 1'b0;            end
        endcase
    end

    // R7: a disabled channel must never come out unmasked
    always_comb begin
        assert_unmask_needs_en_R7: assert (!chan_unmask || chan_en);
    end
endmodule

// File: rtl/tdm_hold_buffer.sv
module tdm_hold_buffer #(
    parameter int WW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [WW-1:0] wr_data,
    input  logic          load_req,
    input  logic          irq_on_ready,
    output logic [WW-1:0] load_word,
    output logic          tx_ready,
    output logic          dma_req,
    output logic          irq,
    output logic          underrun,
    output logic          tx_empty
);
    logic [WW-1:0] hold_q;
    logic [WW-1:0] last_q;
    logic          full_q;

    assign load_word = full_q ? hold_q : last_q;
    assign tx_ready  = ~full_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q   <= '0;
            last_q   <= '0;
            full_q   <= 1'b0;
            dma_req  <= 1'b0;
            irq      <= 1'b0;
            underrun <= 1'b0;
            tx_empty <= 1'b1;
        end else begin
            dma_req  <= 1'b0;
            irq      <= 1'b0;
            underrun <= 1'b0;
            if (load_req) begin
                if (full_q) begin
                    last_q   <= hold_q;
                    full_q   <= 1'b0;
                    dma_req  <= 1'b1;
                    irq      <= irq_on_ready;
                    tx_empty <= 1'b0;
                end else begin
                    underrun <= 1'b1;
                    tx_empty <= 1'b1;
                end
            end
            if (wr) begin
                hold_q <= wr_data;
                full_q <= 1'b1;
            end
        end
    end

    assert_copy_xor_underrun_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dma_req, underrun}));

    assert_irq_with_dma_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> dma_req);

    assert_dma_from_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load_req |=> (dma_req || underrun));
endmodule

// File: rtl/tdm_shifter.sv
module tdm_shifter #(
    parameter int WW = 32,
    localparam int BW = $clog2(WW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slot_start,
    input  logic          chan_en,
    input  logic          chan_unmask,
    input  logic          go_idle,
    input  logic          shift_en,
    input  logic [BW-1:0] word_len_m1,
    input  logic [WW-1:0] load_word,
    output logic          ser_data,
    output logic          ser_oe
);
    logic [WW-1:0] sr_q;
    logic [BW-1:0] align;

    assign align    = BW'(WW - 1) - word_len_m1;
    assign ser_data = ser_oe & sr_q[WW-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q   <= '0;
            ser_oe <= 1'b0;
        end else if (slot_start) begin
            ser_oe <= chan_unmask;
            if (chan_en) sr_q <= load_word << align;
        end else if (go_idle) begin
            ser_oe <= 1'b0;
        end else if (shift_en && ser_oe) begin
            sr_q <= sr_q << 1;
        end
    end
endmodule

// File: rtl/tdm_tx_gate.sv
module tdm_tx_gate
    import tdm_tx_pkg::*;
#(
    parameter int NCH = 128,
    parameter int WW  = 32,
    localparam int CW = $clog2(NCH),
    localparam int BW = $clog2(WW)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fsync,
    input  logic [BW-1:0]  word_len_m1,
    input  logic [CW-1:0]  frame_len_m1,
    input  logic [1:0]     mode,
    input  logic           wide_range,
    input  logic [NCH-1:0] tx_en_map,
    input  logic [NCH-1:0] rx_en_map,
    input  logic           irq_on_ready,
    input  logic           hold_wr,
    input  logic [WW-1:0]  hold_word,
    output logic           ser_data,
    output logic           ser_oe,
    output logic           tx_ready,
    output logic           dma_req,
    output logic           irq,
    output logic           underrun,
    output logic           tx_empty
);
    tx_state_e     state_q, state_d;
    logic [CW-1:0] chan_q;
    logic [BW-1:0] bit_q;

    logic          word_end, frame_end, slot_start, go_idle, shift_en;
    logic [CW-1:0] sel_chan;
    logic          chan_en, chan_unmask;
    logic [WW-1:0] load_word;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and per-cycle control outputs
    always_comb begin
        word_end   = (state_q == ST_SHIFT) && (bit_q == word_len_m1);
        frame_end  = word_end && (chan_q == frame_len_m1);
        slot_start = fsync || (word_end && !frame_end);
        sel_chan   = fsync ? '0 : chan_q + 1'b1;
        go_idle    = 1'b0;
        shift_en   = 1'b0;
        state_d    = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (fsync) state_d = ST_SHIFT;           // FRAME_SYNC
            end
            ST_SHIFT: begin
                shift_en = 1'b1;
                if (fsync) state_d = ST_SHIFT;           // FRAME_SYNC
                else if (frame_end) begin                // FRAME_DONE
                    state_d = ST_IDLE;
                    go_idle = 1'b1;
                end                                      // NEXT_SLOT otherwise
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // slot and bit counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_q <= '0;
            bit_q  <= '0;
        end else if (fsync) begin
            chan_q <= '0;
            bit_q  <= '0;
        end else if (state_q == ST_SHIFT) begin
            if (word_end) begin
                bit_q <= '0;
                if (!frame_end) chan_q <= sel_chan;
            end else begin
                bit_q <= bit_q + 1'b1;
            end
        end
    end

    tdm_chan_select #(.NCH(NCH)) u_select (
        .mode        (mode),
        .wide_range  (wide_range),
        .chan        (sel_chan),
        .tx_map      (tx_en_map),
        .rx_map      (rx_en_map),
        .chan_en     (chan_en),
        .chan_unmask (chan_unmask)
    );

    tdm_hold_buffer #(.WW(WW)) u_hold (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr           (hold_wr),
        .wr_data      (hold_word),
        .load_req     (slot_start && chan_en),
        .irq_on_ready (irq_on_ready),
        .load_word    (load_word),
        .tx_ready     (tx_ready),
        .dma_req      (dma_req),
        .irq          (irq),
        .underrun     (underrun),
        .tx_empty     (tx_empty)
    );

    tdm_shifter #(.WW(WW)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .slot_start  (slot_start),
        .chan_en     (chan_en),
        .chan_unmask (chan_unmask),
        .go_idle     (go_idle),
        .shift_en    (shift_en),
        .word_len_m1 (word_len_m1),
        .load_word   (load_word),
        .ser_data    (ser_data),
        .ser_oe      (ser_oe)
    );

    // R7: output enable only changes at a slot boundary
    assert_oe_steady_in_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && !word_end && !fsync) |=> $stable(ser_oe));

    // R11: nothing is driven between frames
    assert_idle_no_drive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !fsync) |=> !ser_oe);
endmodule

// File: tb/tdm_tx_gate_bench.sv
module tdm_tx_gate_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fsync = 1'b0;
    logic [4:0]   word_len_m1 = 5'd7;
    logic [6:0]   frame_len_m1 = 7'd0;
    logic [1:0]   mode = 2'b00;
    logic         wide_range = 1'b0;
    logic [127:0] tx_en_map = '0;
    logic [127:0] rx_en_map = '0;
    logic         irq_on_ready = 1'b0;
    logic         hold_wr = 1'b0;
    logic [31:0]  hold_word = '0;
    logic ser_data, ser_oe, tx_ready, dma_req, irq, underrun, tx_empty;

    always #4 clk = ~clk;

    tdm_tx_gate u_tdm_tx_gate (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .word_len_m1(word_len_m1),
        .frame_len_m1(frame_len_m1), .mode(mode), .wide_range(wide_range),
        .tx_en_map(tx_en_map), .rx_en_map(rx_en_map), .irq_on_ready(irq_on_ready),
        .hold_wr(hold_wr), .hold_word(hold_word), .ser_data(ser_data), .ser_oe(ser_oe),
        .tx_ready(tx_ready), .dma_req(dma_req), .irq(irq), .underrun(underrun),
        .tx_empty(tx_empty)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [31:0] m_hold = '0;
    logic [31:0] m_last = '0;
    bit m_full = 1'b0;
    bit m_empty = 1'b1;
    int wseq = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] next_word();
        wseq++;
        return (32'(wseq) * 32'h9E3779B1) ^ 32'h5A5A1234;
    endfunction

    // selection model from R2..R6
    task automatic model_sel(input int c, output bit en, output bit unm);
        bit inr, txs, rxs;
        inr = wide_range || (c < 32);
        txs = inr && tx_en_map[c];
        rxs = inr && rx_en_map[c];
        case (mode)
            2'b00: begin en = 1; unm = 1; end
            2'b01: begin en = txs; unm = txs; end
            2'b10: begin en = 1; unm = txs; end
            default: begin en = rxs; unm = rxs && txs; end
        endcase
    endtask

    task automatic set_maps(input int kind);
        for (int c = 0; c < 128; c++) begin
            if (kind == 0) begin
                tx_en_map[c] = (c % 3) != 1;
                rx_en_map[c] = (c % 4) != 2;
            end else begin
                tx_en_map[c] = (c == 0) || (c == 15) || (c == 39);
                rx_en_map[c] = 1'b0;
            end
        end
    endtask

    task automatic run_frame(input logic [1:0] md, input bit wd, input int nf,
                             input int wl, input bit iq, input bit skip);
        bit en, unm, exp_dma, exp_und, exp_bit;
        mode = md; wide_range = wd; frame_len_m1 = 7'(nf - 1);
        word_len_m1 = 5'(wl - 1); irq_on_ready = iq;
        @(negedge clk);
        hold_word = next_word(); hold_wr = 1'b1;
        m_hold = hold_word; m_full = 1;
        @(negedge clk);
        hold_wr = 1'b0; fsync = 1'b1;
        for (int c = 0; c < nf; c++) begin
            model_sel(c, en, unm);
            for (int b = 0; b < wl; b++) begin
                @(negedge clk);
                fsync = 1'b0;
                if (b == 0) begin
                    exp_dma = en && m_full;
                    exp_und = en && !m_full;
                    if (en) begin
                        if (m_full) begin m_last = m_hold; m_full = 0; m_empty = 0; end
                        else m_empty = 1;
                    end
                    chk(dma_req == exp_dma, $sformatf("R8 dma ch%0d", c), dma_req, exp_dma);
                    chk(irq == (exp_dma && iq), $sformatf("R9 irq ch%0d", c), irq, exp_dma && iq);
                    chk(underrun == exp_und, $sformatf("R10 underrun ch%0d", c), underrun, exp_und);
                    chk(tx_empty == m_empty, $sformatf("R10 empty ch%0d", c), tx_empty, m_empty);
                    chk(tx_ready == !m_full, $sformatf("R8 ready ch%0d", c), tx_ready, !m_full);
                end
                if (b == 1)
                    chk(!dma_req && !irq && !underrun, $sformatf("R8 pulse width ch%0d", c),
                        {dma_req, irq, underrun}, 0);
                exp_bit = unm ? m_last[wl - 1 - b] : 1'b0;
                chk(ser_oe == unm, $sformatf("R2-5 oe mode%0d ch%0d bit%0d (R7)", md, c, b), ser_oe, unm);
                chk(ser_data == exp_bit, $sformatf("R7 data ch%0d bit%0d", c, b), ser_data, exp_bit);
                if (b == 2 && !(skip && (c % 5) == 3)) begin
                    hold_word = next_word(); hold_wr = 1'b1;
                    m_hold = hold_word; m_full = 1;
                end
                if (b == 3) hold_wr = 1'b0;
            end
        end
        @(negedge clk);
        chk(ser_oe == 1'b0, "R11 idle after frame", ser_oe, 0);
        @(negedge clk);
        chk(ser_oe == 1'b0 && ser_data == 1'b0, "R11 still idle", ser_oe, 0);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset values
        chk(ser_oe == 0 && ser_data == 0, "R1 line quiet", {ser_oe, ser_data}, 0);
        chk(tx_ready == 1, "R1 ready", tx_ready, 1);
        chk(tx_empty == 1, "R1 empty", tx_empty, 1);
        chk({dma_req, irq, underrun} == 0, "R1 pulses", {dma_req, irq, underrun}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        set_maps(0);
        for (int md = 0; md < 4; md++)
            for (int wd = 0; wd < 2; wd++)
                run_frame(2'(md), wd[0], 40, 8, wd[0], 1'b0);   // R2 R3 R4 R5 R6 R9
        run_frame(2'b11, 1'b1, 128, 8, 1'b1, 1'b0);             // R5 R6 wide
        run_frame(2'b10, 1'b1, 128, 8, 1'b1, 1'b1);             // R10 underrun
        run_frame(2'b01, 1'b0, 40, 8, 1'b0, 1'b1);              // R10 with disabled slots
        run_frame(2'b00, 1'b0, 6, 16, 1'b1, 1'b0);              // R7 word length 16
        run_frame(2'b10, 1'b0, 5, 32, 1'b0, 1'b1);              // R7 word length 32
        set_maps(1);
        run_frame(2'b01, 1'b1, 40, 8, 1'b1, 1'b0);              // R3 sparse channels 0,15,39

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule